// File: doc/BRIEF.md
# Multipath Tapped Delay Line Channel

This block imposes a sparse, time-varying multipath channel on a stream of complex baseband samples. Every accepted input sample enters a shared history. Each of up to nine paths picks one sample out of that history at its own programmable whole-sample delay. The picked sample is multiplied by a complex gain that the path receives afresh with every input sample. The products of all enabled paths are added into one complex output sample.

The gains come from an external generator, which supplies one new complex gain per path alongside each input sample. A per-path enable switches a path off, so a profile with fewer than nine paths runs with the spare paths disabled. At the intended 100 MHz sample rate one delay step is 10 ns. The 512-entry history reaches 5110 ns, which covers the longest profile spacing of 5000 ns. Gains are Q1.15 fixed point. The output is the full-precision sum, rounded half-up at bit 15 and clipped to 16 bits.

Top module: `mpath_channel`

## Requirements
- R1: With `in_valid` high, the result is the sum over enabled paths of (delayed sample × path gain). Both operands are signed 16-bit complex (re = ai·gi − aq·gq, im = ai·gq + aq·gi). The sum is then scaled as `(sum + 16384) >>> 15`.
- R2: Path p uses delay d = `delay_cfg[p*9 +: 9]`, range 0..511. Its operand is the sample accepted d samples before the current one, and d = 0 means the current sample itself.
- R3: The gain a path applies is the value on `gain_i[p*16 +: 16]` / `gain_q[p*16 +: 16]` in the same cycle as the sample. A new gain on each sample takes effect on that sample.
- R4: `out_valid` is high exactly 4 clock cycles after each cycle with `in_valid` high, and at no other time.
- R5: A path whose `path_en[p]` bit is 0 adds nothing to the output, whatever its gain or delay.
- R6: A scaled result above 32767 is output as 32767, and one below −32768 is output as −32768, separately for I and Q.
- R7: The delay and enable inputs are used only in cycles with `in_valid` high. Values present in idle cycles have no effect on any output.
- R8: Only cycles with `in_valid` high add a sample to the history. Idle cycles do not shift the delay line.
- R9: While `out_valid` is low, `out_i` and `out_q` keep the last valid result.
- R10: After synchronous reset, `out_valid`, `out_i` and `out_q` are 0, and the history holds zeros, so taps that reach before the first sample contribute 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input sample, in-phase, signed |
| in_q | input | 16 | Input sample, quadrature, signed |
| delay_cfg | input | 81 | Nine 9-bit path delays, path p at bits p*9+8..p*9 |
| path_en | input | 9 | Per-path enable, bit p for path p |
| gain_i | input | 144 | Nine signed Q1.15 gains, in-phase, path p at bits p*16+15..p*16 |
| gain_q | input | 144 | Nine signed Q1.15 gains, quadrature, same packing |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Channel output, in-phase, signed |
| out_q | output | 16 | Channel output, quadrature, signed |

## Verification
A single path at delay 0 with a half-scale gain checks the rounding and the complex product on its own. Changing the gain sample by sample on that path shows that gains are taken with their own sample and not one sample late. An impulse followed by zeros, fed through paths at distinct delays, places each echo at a separate output position, so a wrong tap address or a swapped gain is visible. A long ramp on a path at delay 511 exercises pointer wrap-around. Other directed cases cover saturation at both rails, disabled paths carrying large gains, delay values changed only during idle cycles, and random input gaps. These show that idle cycles neither move the history nor reach the output. A long random run with random delays, gains and enables then compares every output against a software model of the channel.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int SW     = 16;          // sample and gain width
    localparam int FRAC   = SW - 1;      // gain fraction bits (Q1.15)
    localparam int PW     = 2 * SW + 1;  // width of one complex product component
    localparam int ACC_W  = PW + 4;      // room for up to 16 summed paths

    typedef struct packed {
        logic signed [SW-1:0] re;
        logic signed [SW-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [PW-1:0] re;
        logic signed [PW-1:0] im;
    } prod_t;

    typedef struct packed {
        logic signed [ACC_W-1:0] re;
        logic signed [ACC_W-1:0] im;
    } acc_t;

    // round half up at the binary point, then clip to SW bits
    function automatic logic signed [SW-1:0] round_sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W:0] r;
        logic signed [ACC_W:0] hi;
        logic signed [ACC_W:0] lo;
        hi = (ACC_W+1)'(2 ** (SW - 1) - 1);
        lo = -hi - 1;
        r  = {v[ACC_W-1], v} + (ACC_W+1)'(2 ** (FRAC - 1));
        r  = r >>> FRAC;
        if (r > hi)      return hi[SW-1:0];
        else if (r < lo) return lo[SW-1:0];
        else             return r[SW-1:0];
    endfunction

endpackage

// File: rtl/mpc_delay_line.sv
module mpc_delay_line
    import mpc_pkg::*;
#(
    parameter int NPATH = 9,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  cplx_t                 wr_data,
    input  logic [NPATH*AW-1:0]   delay_flat,
    output cplx_t [NPATH-1:0]     taps,
    output logic [AW-1:0]         wptr
);

    cplx_t mem [DEPTH];
    cplx_t [NPATH-1:0] rd;

    always_comb begin
        for (int p = 0; p < NPATH; p++) begin
            logic [AW-1:0] d;
            d = delay_flat[p*AW +: AW];
            if (d == '0) rd[p] = wr_data;
            else         rd[p] = mem[AW'(wptr - d)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            taps <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wptr] <= wr_data;
            wptr      <= wptr + 1'b1;
            taps      <= rd;
        end
    end

endmodule

// File: rtl/mpc_cmul.sv
module mpc_cmul
    import mpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  logic  gate,
    input  cplx_t a,
    input  cplx_t b,
    output prod_t y
);

    logic signed [PW-1:0] rr, qq, rq, qr;

    always_comb begin
        rr = PW'($signed(a.re)) * PW'($signed(b.re));
        qq = PW'($signed(a.im)) * PW'($signed(b.im));
        rq = PW'($signed(a.re)) * PW'($signed(b.im));
        qr = PW'($signed(a.im)) * PW'($signed(b.re));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else if (valid) begin
            if (gate) begin
                y.re <= rr - qq;
                y.im <= rq + qr;
            end else begin
                y <= '0;
            end
        end
    end

endmodule

// File: rtl/mpc_sum_round.sv
module mpc_sum_round
    import mpc_pkg::*;
#(
    parameter int NPATH = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              v_in,
    input  prod_t [NPATH-1:0] prods,
    output logic              v_out,
    output cplx_t             y
);

    acc_t acc_d, acc_q;
    logic v_acc;

    always_comb begin
        acc_d = '0;
        for (int p = 0; p < NPATH; p++) begin
            acc_d.re = acc_d.re + ACC_W'(prods[p].re);
            acc_d.im = acc_d.im + ACC_W'(prods[p].im);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            v_acc <= 1'b0;
            y     <= '0;
            v_out <= 1'b0;
        end else begin
            v_acc <= v_in;
            v_out <= v_acc;
            if (v_in)  acc_q <= acc_d;
            if (v_acc) begin
                y.re <= round_sat(acc_q.re);
                y.im <= round_sat(acc_q.im);
            end
        end
    end

endmodule

// File: rtl/mpath_channel.sv
module mpath_channel
    import mpc_pkg::*;
#(
    parameter int NPATH = 9,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [SW-1:0]   in_i,
    input  logic signed [SW-1:0]   in_q,
    input  logic [NPATH*AW-1:0]    delay_cfg,
    input  logic [NPATH-1:0]       path_en,
    input  logic [NPATH*SW-1:0]    gain_i,
    input  logic [NPATH*SW-1:0]    gain_q,
    output logic                   out_valid,
    output logic signed [SW-1:0]   out_i,
    output logic signed [SW-1:0]   out_q
);

    cplx_t              sample;
    cplx_t [NPATH-1:0]  taps;
    cplx_t [NPATH-1:0]  gain_s1;
    logic  [NPATH-1:0]  en_s1;
    logic               v_s1;
    prod_t [NPATH-1:0]  prods;
    logic               v_s2;
    logic  [AW-1:0]     wr_ptr;
    cplx_t              y;

    assign sample.re = in_i;
    assign sample.im = in_q;

    mpc_delay_line #(.NPATH(NPATH), .DEPTH(DEPTH)) u_dline (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (in_valid),
        .wr_data    (sample),
        .delay_flat (delay_cfg),
        .taps       (taps),
        .wptr       (wr_ptr)
    );

    // gains and enables aligned with the registered taps
    always_ff @(posedge clk) begin
        if (rst) begin
            gain_s1 <= '0;
            en_s1   <= '0;
            v_s1    <= 1'b0;
            v_s2    <= 1'b0;
        end else begin
            v_s1 <= in_valid;
            v_s2 <= v_s1;
            if (in_valid) begin
                en_s1 <= path_en;
                for (int p = 0; p < NPATH; p++) begin
                    gain_s1[p].re <= gain_i[p*SW +: SW];
                    gain_s1[p].im <= gain_q[p*SW +: SW];
                end
            end
        end
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        mpc_cmul u_cmul (
            .clk   (clk),
            .rst   (rst),
            .valid (v_s1),
            .gate  (en_s1[p]),
            .a     (taps[p]),
            .b     (gain_s1[p]),
            .y     (prods[p])
        );
    end

    mpc_sum_round #(.NPATH(NPATH)) u_sum (
        .clk   (clk),
        .rst   (rst),
        .v_in  (v_s2),
        .prods (prods),
        .v_out (out_valid),
        .y     (y)
    );

    assign out_i = y.re;
    assign out_q = y.im;

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
    parameter int NPATH = 9,
    parameter int AW    = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [NPATH-1:0]  path_en,
    input logic              out_valid,
    input logic [15:0]       out_i,
    input logic [15:0]       out_q,
    input logic [AW-1:0]     wptr
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));  // R4

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4 && out_valid && $past(path_en, 4) == '0 && $past(in_valid, 4))
        |-> (out_i == '0 && out_q == '0));  // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd0 && !out_valid) |-> ($stable(out_i) && $stable(out_q)));  // R9

    AST_PTR_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd0) |-> (wptr == AW'($past(wptr) + AW'($past(in_valid)))));  // R8

endmodule

bind mpath_channel mpc_checker #(.NPATH(NPATH), .AW(AW)) u_mpc_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .path_en   (path_en),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .wptr      (wr_ptr)
);

// File: tb/test_mpath_channel.sv
module test_mpath_channel;

    localparam int NP = 9;
    localparam int AW = 9;
    localparam int HMAX = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic [NP*AW-1:0] delay_cfg = '0;
    logic [NP-1:0] path_en = '0;
    logic [NP*16-1:0] gain_i = '0, gain_q = '0;
    logic out_valid;
    logic signed [15:0] out_i, out_q;

    always #4 clk = ~clk;

    mpath_channel i_mpath_channel (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .delay_cfg(delay_cfg), .path_en(path_en), .gain_i(gain_i), .gain_q(gain_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench-side channel model state
    int hist_i [HMAX];
    int hist_q [HMAX];
    int n_smp = 0;
    int dly [NP];
    int gi [NP];
    int gq [NP];
    bit en [NP];

    int    q_i[$], q_q[$], q_c[$];
    string q_t[$];
    int    last_i = 0, last_q = 0;

    function automatic int rnd_sat(longint acc);
        longint r;
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic put_sample(string tag, int xi, int xq);
        longint ar, ai;
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_i = 16'(xi);
        in_q = 16'(xq);
        for (int p = 0; p < NP; p++) begin
            delay_cfg[p*AW +: AW] = AW'(dly[p]);
            path_en[p] = en[p];
            gain_i[p*16 +: 16] = 16'(gi[p]);
            gain_q[p*16 +: 16] = 16'(gq[p]);
        end
        hist_i[n_smp] = xi;
        hist_q[n_smp] = xq;
        ar = 0; ai = 0;
        for (int p = 0; p < NP; p++) begin
            int k, ti, tq;
            k = n_smp - dly[p];
            ti = (k >= 0) ? hist_i[k] : 0;
            tq = (k >= 0) ? hist_q[k] : 0;
            if (en[p]) begin
                ar += longint'(ti) * gi[p] - longint'(tq) * gq[p];
                ai += longint'(ti) * gq[p] + longint'(tq) * gi[p];
            end
        end
        n_smp++;
        q_i.push_back(rnd_sat(ar));
        q_q.push_back(rnd_sat(ai));
        q_c.push_back(cyc + 4);
        q_t.push_back(tag);
    endtask

    task automatic idle(int k, bit scramble);
        for (int j = 0; j < k; j++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_i = 16'($urandom);
            if (scramble) begin
                delay_cfg = {$urandom, $urandom, $urandom};
                path_en   = NP'($urandom);
            end
        end
    endtask

    task automatic drain();
        idle(8, 1'b0);
    endtask

    task automatic cfg_off();
        for (int p = 0; p < NP; p++) begin
            dly[p] = 0; gi[p] = 0; gq[p] = 0; en[p] = 1'b0;
        end
    endtask

    // output monitor away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q_c.size() == 0) begin
                    chk("R4", 1, 0, "unexpected out_valid");
                end else begin
                    int ei, eq, ec;
                    string t;
                    ei = q_i.pop_front(); eq = q_q.pop_front();
                    ec = q_c.pop_front(); t = q_t.pop_front();
                    chk("R4", cyc, ec, "out_valid cycle");
                    chk(t, int'(out_i), ei, "out_i");
                    chk(t, int'(out_q), eq, "out_q");
                end
                last_i = int'(out_i);
                last_q = int'(out_q);
            end else begin
                if (q_c.size() != 0 && q_c[0] <= cyc)
                    chk("R4", 0, 1, "missing out_valid");
                chk("R9", int'(out_i), last_i, "held out_i");
                chk("R9", int'(out_q), last_q, "held out_q");
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 1, 0, "timeout");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20111));
        cfg_off();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R10", int'(out_valid), 0, "reset out_valid");
        chk("R10", int'(out_i), 0, "reset out_i");
        chk("R10", int'(out_q), 0, "reset out_q");

        // R10: taps reaching before the first sample read zero history
        en[0] = 1; dly[0] = 100; gi[0] = 32767;
        en[1] = 1; dly[1] = 0;   gi[1] = 8192; gq[1] = -4096;
        for (int s = 0; s < 4; s++) put_sample("R10", 20000 - s * 7000, -3000 + s);
        drain();

        // R1: single path, half gain, rounding on odd values
        cfg_off(); en[0] = 1; gi[0] = 16384;
        put_sample("R1", 1, -1);
        put_sample("R1", 3, -3);
        put_sample("R1", 32767, -32768);
        put_sample("R1", -12345, 777);
        drain();

        // R3: gain changes every sample
        cfg_off(); en[2] = 1;
        for (int s = 0; s < 6; s++) begin
            gi[2] = 5000 * s - 12000;
            gq[2] = 30000 - 9000 * s;
            put_sample("R3", 10000 + s, -7000 + 3 * s);
        end
        drain();

        // R2: impulse through three distinct delays, then zeros
        cfg_off();
        en[0] = 1; dly[0] = 0; gi[0] = 32767;
        en[4] = 1; dly[4] = 1; gq[4] = 16384;
        en[8] = 1; dly[8] = 5; gi[8] = -8192;
        put_sample("R2", 20000, 0);
        for (int s = 0; s < 8; s++) put_sample("R2", 0, 0);
        drain();

        // R2: maximum delay 511 with pointer wrap
        cfg_off();
        en[3] = 1; dly[3] = 511; gi[3] = 32767;
        en[6] = 1; dly[6] = 2;   gq[6] = 1000;
        for (int s = 0; s < 530; s++) put_sample("R2", (s * 37) % 30000 - 15000, s);
        drain();

        // R5: seven-path profile, two spare paths carry large gains but are off
        cfg_off();
        for (int p = 0; p < NP; p++) begin
            dly[p] = p * 3;
            gi[p] = (p < 7) ? 2000 + p : 32767;
            gq[p] = (p < 7) ? -1000 : 32767;
            en[p] = (p < 7);
        end
        for (int s = 0; s < 30; s++) put_sample("R5", 15000 - s * 500, s * 400);
        drain();

        // R6: saturation at both rails
        cfg_off();
        for (int p = 0; p < NP; p++) begin en[p] = 1; gi[p] = 32767; end
        put_sample("R6", 32767, -32768);
        put_sample("R6", -32768, 32767);
        drain();

        // R7: delays and enables scrambled only while idle
        cfg_off();
        en[1] = 1; dly[1] = 4; gi[1] = 12000; gq[1] = 3000;
        en[5] = 1; dly[5] = 9; gi[5] = -7000;
        for (int s = 0; s < 20; s++) begin
            put_sample("R7", 1000 * s - 9000, 4000 - 300 * s);
            idle(1 + s % 3, 1'b1);
        end
        drain();

        // R8: random gaps between samples do not shift the history
        cfg_off();
        en[0] = 1; dly[0] = 1; gi[0] = 20000;
        en[7] = 1; dly[7] = 3; gq[7] = -15000;
        for (int s = 0; s < 40; s++) begin
            put_sample("R8", int'($urandom_range(0, 40000)) - 20000, int'($urandom_range(0, 40000)) - 20000);
            if ($urandom_range(0, 1) == 1) idle(int'($urandom_range(1, 4)), 1'b0);
        end
        drain();

        // R1: random profiles, gains refreshed every sample, random gaps
        for (int blk = 0; blk < 6; blk++) begin
            for (int p = 0; p < NP; p++) begin
                dly[p] = int'($urandom_range(0, 511));
                en[p]  = ($urandom_range(0, 3) != 0);
            end
            for (int s = 0; s < 250; s++) begin
                for (int p = 0; p < NP; p++) begin
                    gi[p] = int'($urandom_range(0, 16000)) - 8000;
                    gq[p] = int'($urandom_range(0, 16000)) - 8000;
                end
                put_sample("R1", int'($urandom_range(0, 65535)) - 32768,
                                 int'($urandom_range(0, 65535)) - 32768);
                if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 3)), 1'b1);
            end
        end
        drain();

        chk("R4", q_c.size(), 0, "pending results");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule